// File: doc/BRIEF.md
# Link Receiver-Detect Sub-State Controller

This block is the front end of a serial link training state machine. It owns the two receiver-detect sub-states, Quiet and Active, for up to `LANES` lanes. In Quiet it waits for a fixed timeout or for an enabled lane to leave electrical idle. In Active it issues a single receiver-detect request to the PHY and evaluates the per-lane answer. When a receiver is found, it leaves the detect phase with a one-cycle exit strobe and a mask of the detected lanes. Otherwise it goes back to Quiet and every Quiet timer starts again.

Two protections prevent back-to-back receiver detections, which would not leave time for the transmit lines to discharge. First, a programmable minimum dwell, selected by a 2-bit code and captured on each entry to Quiet, holds off any exit caused by electrical-idle activity. Second, lanes not enabled for the link are treated as idle, so an unused lane cannot end Quiet early. All times are counted in microseconds. A tick prescaler derives the microsecond from the `CLK_MHZ` parameter.

Top module: `ldc_detect_ctrl`

## Requirements
- R1: While `rst_ni` is low, and in the cycle after `link_disable_i` is sampled high, the outputs read as follows: `state_o` is Quiet (2'b00), `det_req_o` is 0, `exit_o` is 0 and `det_lanes_o` is 0. Quiet timing then restarts from zero on the first cycle with the reset or disable released. That cycle is the entry cycle.
- R2: Suppose no enabled lane leaves electrical idle. Then `state_o` stays Quiet for exactly `QUIET_US*CLK_MHZ+2` consecutive cycles, counting the entry cycle, and then changes to Active (2'b01).
- R3: With dwell code 00, suppose an enabled lane shows `elec_idle_i`=0 in cycle a, where the entry cycle is cycle 0. Then Quiet lasts max(a,1)+1 cycles. The entry cycle itself never ends Quiet.
- R4: The dwell codes map as follows: 00 gives 0 us, 01 gives `DWELL1_US`, 10 gives `DWELL2_US` and 11 gives `DWELL3_US`. Electrical-idle activity cannot end Quiet before cycle D*CLK_MHZ+1. Quiet therefore lasts min(QUIET_US*CLK_MHZ+1, max(a, D*CLK_MHZ+1))+1 cycles.
- R5: A lane with `lane_en_i`=0 behaves as idle, and its `det_rx_i` bit is ignored. Activity on such a lane never shortens Quiet, and a receiver on such a lane never causes an exit.
- R6: `dwell_sel_i` is captured in the entry cycle. A change made later in the same Quiet visit has no effect until the next entry.
- R7: `det_req_o` is high only in the first cycle of each Active visit. It stays low in Quiet and while Active waits for the PHY.
- R8: A `det_done_i` pulse in Active with `det_rx_i & lane_en_i` equal to 0 returns the block to Quiet. The timers restart and a new dwell code is captured.
- R9: A `det_done_i` pulse in Active with `det_rx_i & lane_en_i` not equal to 0 moves `state_o` to Exited (2'b10). `exit_o` is high for exactly the first Exited cycle. `det_lanes_o` shows `det_rx_i & lane_en_i` and holds it until reset or disable.
- R10: `det_done_i` is ignored outside Active. A pulse during Quiet changes neither the state nor the Quiet duration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| link_disable_i | input | 1 | Synchronous return to Quiet with timers cleared |
| lane_en_i | input | LANES | Lanes assigned to the link |
| elec_idle_i | input | LANES | Per-lane electrical idle, 1 = idle |
| dwell_sel_i | input | 2 | Minimum Quiet dwell code |
| det_req_o | output | 1 | One-cycle receiver-detect request to the PHY |
| det_done_i | input | 1 | PHY detect-complete pulse |
| det_rx_i | input | LANES | Per-lane receiver-present result, valid with det_done_i |
| state_o | output | 2 | 00 Quiet, 01 Active, 10 Exited |
| exit_o | output | 1 | One-cycle strobe on leaving detect |
| det_lanes_o | output | LANES | Enabled lanes that reported a receiver |

## Verification
The bench builds the block with `CLK_MHZ`=2, `QUIET_US`=60 and dwells of 5, 10 and 20 us, with four lanes. With these values the Quiet timeout is 122 cycles and every dwell code produces a distinct, short hold-off. Within a few thousand cycles the bench can therefore reach the saturation of dwell against timeout, a change of the dwell code in mid-visit, and long runs of failed detections that re-enter Quiet.

// File: rtl/ldc_pkg.sv
package ldc_pkg;
  typedef enum logic [1:0] {
    ST_QUIET  = 2'b00,
    ST_ACTIVE = 2'b01,
    ST_EXIT   = 2'b10
  } ldc_state_e;
endpackage

// File: rtl/ldc_us_tick.sv
module ldc_us_tick #(
  parameter int CLK_MHZ = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int PRE_W = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_MHZ - 1);

  logic [PRE_W-1:0] pre_q;

  assign tick_o = !clr_i && (pre_q == PRE_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pre_q <= '0;
    else if (clr_i || tick_o)    pre_q <= '0;
    else                         pre_q <= pre_q + 1'b1;
  end

  p_pre_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= PRE_LAST);
endmodule

// File: rtl/ldc_quiet_timer.sv
module ldc_quiet_timer #(
  parameter int QUIET_US = 12000,
  parameter int US_W     = $clog2(QUIET_US + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            tick_i,
  input  logic [US_W-1:0] dwell_i,
  output logic            dwell_ok_o,
  output logic            timeout_o
);
  localparam logic [US_W-1:0] US_MAX = US_W'(QUIET_US);

  logic [US_W-1:0] us_q;
  logic [US_W-1:0] dwell_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      us_q    <= '0;
      dwell_q <= '0;
    end else if (clr_i) begin
      us_q    <= '0;
      dwell_q <= dwell_i;   // captured once per entry
    end else if (tick_i && us_q != US_MAX) begin
      us_q    <= us_q + 1'b1;
    end
  end

  assign dwell_ok_o = !clr_i && (us_q >= dwell_q);
  assign timeout_o  = !clr_i && (us_q == US_MAX);

  p_cnt_cap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    us_q <= US_MAX);
  p_dwell_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> $stable(dwell_q));
endmodule

// File: rtl/ldc_lane_mask.sv
module ldc_lane_mask #(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0] lane_en_i,
  input  logic [LANES-1:0] elec_idle_i,
  input  logic [LANES-1:0] det_rx_i,
  output logic             act_any_o,
  output logic [LANES-1:0] rx_mask_o,
  output logic             rx_any_o
);
  logic [LANES-1:0] idle_eff;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    // unassigned lanes read as idle and never report a receiver
    assign idle_eff[l]  = elec_idle_i[l] | ~lane_en_i[l];
    assign rx_mask_o[l] = det_rx_i[l] & lane_en_i[l];
  end

  assign act_any_o = ~&idle_eff;
  assign rx_any_o  = |rx_mask_o;
endmodule

// File: rtl/ldc_detect_ctrl.sv
module ldc_detect_ctrl
  import ldc_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int CLK_MHZ   = 100,
  parameter int QUIET_US  = 12000,
  parameter int DWELL1_US = 100,
  parameter int DWELL2_US = 1000,
  parameter int DWELL3_US = 2000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             link_disable_i,
  input  logic [LANES-1:0] lane_en_i,
  input  logic [LANES-1:0] elec_idle_i,
  input  logic [1:0]       dwell_sel_i,
  output logic             det_req_o,
  input  logic             det_done_i,
  input  logic [LANES-1:0] det_rx_i,
  output logic [1:0]       state_o,
  output logic             exit_o,
  output logic [LANES-1:0] det_lanes_o
);
  localparam int US_W = $clog2(QUIET_US + 1);

  ldc_state_e       state_q;
  logic             entry_q;
  logic             req_sent_q;
  logic             exit_q;
  logic [LANES-1:0] lanes_q;

  logic             tick, dwell_ok, timeout;
  logic             act_any, rx_any;
  logic [LANES-1:0] rx_mask;
  logic [US_W-1:0]  dwell_us;

  always_comb begin
    unique case (dwell_sel_i)
      2'b00:   dwell_us = '0;
      2'b01:   dwell_us = US_W'(DWELL1_US);
      2'b10:   dwell_us = US_W'(DWELL2_US);
      default: dwell_us = US_W'(DWELL3_US);
    endcase
  end

  ldc_us_tick #(.CLK_MHZ(CLK_MHZ)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (entry_q),
    .tick_o (tick)
  );

  ldc_quiet_timer #(.QUIET_US(QUIET_US), .US_W(US_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (entry_q),
    .tick_i     (tick),
    .dwell_i    (dwell_us),
    .dwell_ok_o (dwell_ok),
    .timeout_o  (timeout)
  );

  ldc_lane_mask #(.LANES(LANES)) u_mask (
    .lane_en_i   (lane_en_i),
    .elec_idle_i (elec_idle_i),
    .det_rx_i    (det_rx_i),
    .act_any_o   (act_any),
    .rx_mask_o   (rx_mask),
    .rx_any_o    (rx_any)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_QUIET;
      entry_q    <= 1'b1;
      req_sent_q <= 1'b0;
      exit_q     <= 1'b0;
      lanes_q    <= '0;
    end else if (link_disable_i) begin
      state_q    <= ST_QUIET;
      entry_q    <= 1'b1;
      req_sent_q <= 1'b0;
      exit_q     <= 1'b0;
      lanes_q    <= '0;
    end else begin
      entry_q <= 1'b0;
      exit_q  <= 1'b0;
      unique case (state_q)
        ST_QUIET: begin
          req_sent_q <= 1'b0;
          if (!entry_q && (timeout || (act_any && dwell_ok)))
            state_q <= ST_ACTIVE;
        end
        ST_ACTIVE: begin
          if (!req_sent_q) begin
            req_sent_q <= 1'b1;
          end else if (det_done_i) begin
            if (rx_any) begin
              state_q <= ST_EXIT;
              exit_q  <= 1'b1;
              lanes_q <= rx_mask;
            end else begin
              state_q <= ST_QUIET;
              entry_q <= 1'b1;   // restart timers, recapture dwell
            end
          end
        end
        ST_EXIT: ;
        default: state_q <= ST_QUIET;
      endcase
    end
  end

  assign det_req_o   = (state_q == ST_ACTIVE) && !req_sent_q;
  assign state_o     = state_q;
  assign exit_o      = exit_q;
  assign det_lanes_o = lanes_q;

  p_req_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_req_o |=> !det_req_o);
  p_exit_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_o |=> !exit_o);
  p_exit_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(exit_o) |-> ($past(state_q) == ST_ACTIVE) && $past(det_done_i));
  p_exit_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EXIT && !link_disable_i) |=> (state_q == ST_EXIT) && $stable(det_lanes_o));
  p_disable_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_disable_i |=> (state_o == ST_QUIET) && !det_req_o && !exit_o && (det_lanes_o == '0));
  p_exit_lanes_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_o |-> ((det_lanes_o & ~lane_en_i) == '0) && (det_lanes_o != '0));
endmodule

// File: tb/ldc_detect_ctrl_bench.sv
module ldc_detect_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4;
  localparam int MHZ = 2;
  localparam int QUS = 60;
  localparam int D1 = 5, D2 = 10, D3 = 20;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic link_disable = 1'b0;
  logic [LANES-1:0] lane_en = '1;
  logic [LANES-1:0] elec_idle = '1;
  logic [1:0] dwell_sel = 2'b00;
  logic det_req;
  logic det_done = 1'b0;
  logic [LANES-1:0] det_rx = '0;
  logic [1:0] state;
  logic exit_s;
  logic [LANES-1:0] det_lanes;

  int n_chk = 0, n_err = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldc_detect_ctrl #(
    .LANES(LANES), .CLK_MHZ(MHZ), .QUIET_US(QUS),
    .DWELL1_US(D1), .DWELL2_US(D2), .DWELL3_US(D3)
  ) u_ldc_detect_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .link_disable_i(link_disable),
    .lane_en_i(lane_en), .elec_idle_i(elec_idle), .dwell_sel_i(dwell_sel),
    .det_req_o(det_req), .det_done_i(det_done), .det_rx_i(det_rx),
    .state_o(state), .exit_o(exit_s), .det_lanes_o(det_lanes)
  );

  task automatic check(input string r, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic int dwell_of(input logic [1:0] c);
    case (c)
      2'd0: return 0;
      2'd1: return D1;
      2'd2: return D2;
      default: return D3;
    endcase
  endfunction

  // expected Quiet length in cycles, entry cycle included; act<0 = no activity
  function automatic int exp_len(input logic [1:0] c, input int act);
    int tmo, j, e;
    tmo = QUS * MHZ + 1;
    j = tmo;
    if (act >= 0) begin
      e = dwell_of(c) * MHZ + 1;
      if (act > e) e = act;
      if (e < tmo) j = e;
    end
    return j + 1;
  endfunction

  task automatic quiet_phase(input int act, input logic [3:0] amask, input int chg,
                             input logic [1:0] chg_code, input int dpulse, output int len);
    int req_seen;
    len = 0;
    req_seen = 0;
    while (state == 2'b00) begin
      if (det_req) req_seen++;
      if (len == act) elec_idle = ~amask;
      if (len == chg) dwell_sel = chg_code;
      det_done = (len == dpulse);
      det_rx = (len == dpulse) ? 4'hF : 4'h0;
      len++;
      @(negedge clk);
    end
    det_done = 1'b0;
    det_rx = '0;
    elec_idle = '1;
    check("R7 req low in quiet", req_seen, 0);
  endtask

  task automatic active_phase(input int waitc, input logic [3:0] rx, input logic [1:0] nxt);
    logic [3:0] m;
    check("R7 req in first active cycle", int'(det_req), 1);
    check("R2 state active", int'(state), 1);
    @(negedge clk);
    check("R7 req dropped", int'(det_req), 0);
    for (int i = 0; i < waitc; i++) @(negedge clk);
    check("R7 still active waiting", int'(state), 1);
    dwell_sel = nxt;
    det_done = 1'b1;
    det_rx = rx;
    @(negedge clk);
    det_done = 1'b0;
    det_rx = '0;
    m = rx & lane_en;
    if (m != 0) begin
      check("R9 exited state", int'(state), 2);
      check("R9 exit strobe", int'(exit_s), 1);
      check("R9 lanes", int'(det_lanes), int'(m));
      @(negedge clk);
      check("R9 strobe one cycle", int'(exit_s), 0);
      check("R9 lanes held", int'(det_lanes), int'(m));
      check("R9 state held", int'(state), 2);
    end else begin
      check("R8 back to quiet", int'(state), 0);
      check("R8 no exit", int'(exit_s), 0);
    end
  endtask

  task automatic disable_pulse();
    link_disable = 1'b1;
    @(negedge clk);
    check("R1 disable state", int'(state), 0);
    check("R1 disable req", int'(det_req), 0);
    check("R1 disable exit", int'(exit_s), 0);
    check("R1 disable lanes", int'(det_lanes), 0);
    link_disable = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int len, act;
    logic [1:0] code, nxt;
    logic [3:0] amask, rx;
    void'($urandom(32'd7331));
    repeat (3) @(negedge clk);
    check("R1 reset state", int'(state), 0);
    check("R1 reset req", int'(det_req), 0);
    check("R1 reset exit", int'(exit_s), 0);
    check("R1 reset lanes", int'(det_lanes), 0);
    rst_ni = 1'b1;

    // timeout with no activity
    quiet_phase(-1, 4'h0, -1, 2'd0, -1, len);
    check("R2 timeout length", len, exp_len(2'd0, -1));
    active_phase(0, 4'h0, 2'd2);
    // dwell 10us holds off early activity; re-entry after failed detect
    quiet_phase(3, 4'b0001, -1, 2'd0, -1, len);
    check("R4 R8 dwell code 10", len, exp_len(2'd2, 3));
    active_phase(1, 4'h0, 2'd3);
    // code change mid-visit ignored
    quiet_phase(2, 4'b0100, 2, 2'd0, -1, len);
    check("R6 latched code 11", len, exp_len(2'd3, 2));
    active_phase(2, 4'h0, 2'd0);
    // new code applies on next entry; activity in entry cycle
    quiet_phase(0, 4'b1000, -1, 2'd0, -1, len);
    check("R3 R6 code 00 entry activity", len, exp_len(2'd0, 0));
    active_phase(0, 4'h0, 2'd1);
    // unused lanes active, done in quiet ignored
    lane_en = 4'b0011;
    quiet_phase(0, 4'b1100, -1, 2'd0, 4, len);
    check("R5 R10 unused lanes, stray done", len, exp_len(2'd1, -1));
    active_phase(0, 4'b1100, 2'd1);
    check("R5 unused lane receiver ignored", int'(state), 0);
    quiet_phase(0, 4'b0010, -1, 2'd0, -1, len);
    check("R4 code 01", len, exp_len(2'd1, 0));
    active_phase(0, 4'b0110, 2'd2);
    disable_pulse();

    code = 2'd2;
    for (int t = 0; t < 30; t++) begin
      lane_en = 4'($urandom_range(1, 15));
      amask = 4'($urandom);
      act = ($urandom_range(0, 3) == 0) ? -1 : int'($urandom_range(0, 130));
      quiet_phase(act, amask, -1, 2'd0, -1, len);
      check("R4 random quiet length", len,
            exp_len(code, ((amask & lane_en) != 0) ? act : -1));
      rx = 4'($urandom);
      nxt = 2'($urandom);
      active_phase(int'($urandom_range(0, 3)), rx, nxt);
      if ((rx & lane_en) != 0) disable_pulse();
      code = nxt;
    end

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule